// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block merges interrupt requests from a USB core sub-bank, a DMA sub-bank and a bus-voltage status monitor into one 32-bit top-level pending register. It drives a single interrupt line. Each level has its own mask. Sources are written in through set addresses and cleared through clear addresses on a small 32-bit register bus. The USB sub-bank folds into two top-level summary bits, one for the low half-word (transmit) and one for the high half-word (receive). The DMA sub-bank folds into one top-level summary bit.

The output line has a selectable sense. In active-high sense it asserts while any unmasked top-level bit is pending. In inverted sense it asserts while none is pending. In both senses the line is gated by an enable that is dropped as soon as the power input rises. The enable is restored only after a fixed hold-off counted in clock cycles, and only if power is still on at that point. Inputs for bus voltage and session are also fed into an OTG status word that software can read.

Top module: `intr_rollup`

## Requirements
- R1: The byte offsets are as follows. 0x00, 0x04 and 0x08 are top pending, set and clear, and 0x0C is the top mask. 0x10 to 0x1C are the same four for the USB sub-bank, and 0x20 to 0x2C are the same four for the DMA sub-bank. 0x30 is the config register and 0x34 is the read-only status word. A write to a set offset ORs the written bits into that pending register. A read at the pending, set or clear offset returns the pending value. rdata_o is zero when rd_i is low.
- R2: A write to a clear offset clears exactly the written bits of that pending register.
- R3: After reset, the top mask reads 0xFFFFFFFF. The top pending register, both sub-bank masks and the config register read zero, and irq_o is low.
- R4: Top bit 9 reads 1 exactly when any unmasked USB sub-bank bit in 15:0 is pending. Top bit 8 does the same for bits 31:16. Both follow every USB set, clear or mask write on the next clock edge.
- R5: Top bit 24 reads 1 exactly when any unmasked DMA sub-bank bit is pending. It returns to 0 once no unmasked DMA bit remains.
- R6: Writes to top set or clear at bit positions 8, 9 and 24 have no effect. Those positions always show the sub-bank summaries.
- R7: When config bit 17 is 1, irq_o is high if any top-level bit with mask 0 is pending. When config bit 17 is 0, irq_o is high only if no such bit is pending. In both senses irq_o is low while the enable gate is off.
- R8: A rising power input turns the enable gate off at the next edge. The gate turns back on HOLD_CYC cycles after that edge, provided power is still high.
- R9: A falling power input leaves the gate as it is. If power falls during the hold-off, the gate stays off until a later rise completes its own hold-off.
- R10: Status bit 5 follows vbus_i. Top bit 15 becomes pending on the edge where bit 5 changes value, and only then.
- R11: With sess_i at 1, status bit 6 is 1 and bit 7 is 0. With sess_i at 0 the two bits are reversed. A session change sets no pending bit.
- R12: A write to the config register or to any mask register changes irq_o on the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| vbus_i | input | 1 | Bus voltage valid level |
| sess_i | input | 1 | Session valid level |
| pwr_i | input | 1 | Power-on level |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench probes the exact cycle in which the hold-off ends. A counter that is off by one would turn the line on a cycle early or late. It also drops power partway through a hold-off. A gate that ignored the power level would come back on regardless. The half-word split of the USB sub-bank is tested by masking one half at a time. A swapped summary would light bit 8 where bit 9 belongs. The bench writes to the top-level summary bit positions, where a design that stored those writes would leave stale pending bits. It also holds vbus steady after clearing bit 15, to catch a design that raises the change flag on level rather than on edge.

// File: rtl/intr_rollup_pkg.sv
package intr_rollup_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [3:0] {
    SEL_TOP_PEND = 4'd0,
    SEL_TOP_SET  = 4'd1,
    SEL_TOP_CLR  = 4'd2,
    SEL_TOP_MSK  = 4'd3,
    SEL_USB_PEND = 4'd4,
    SEL_USB_SET  = 4'd5,
    SEL_USB_CLR  = 4'd6,
    SEL_USB_MSK  = 4'd7,
    SEL_DMA_PEND = 4'd8,
    SEL_DMA_SET  = 4'd9,
    SEL_DMA_CLR  = 4'd10,
    SEL_DMA_MSK  = 4'd11,
    SEL_CFG      = 4'd12,
    SEL_STAT     = 4'd13
  } reg_sel_e;

  localparam int unsigned BIT_RX       = 8;
  localparam int unsigned BIT_TX       = 9;
  localparam int unsigned BIT_VBUS_CHG = 15;
  localparam int unsigned BIT_DMA      = 24;
  localparam int unsigned CFG_POL_BIT  = 17;
  localparam int unsigned ST_VBUS      = 5;
  localparam int unsigned ST_SVALID    = 6;
  localparam int unsigned ST_SEND      = 7;

  typedef struct packed {
    logic set;
    logic clr;
    logic msk;
  } bank_we_t;
endpackage

// File: rtl/intr_sub_bank.sv
module intr_sub_bank
  import intr_rollup_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  bank_we_t     we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] pend_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      if (we_i.set)      pend_q <= pend_q | wdata_i;
      else if (we_i.clr) pend_q <= pend_q & ~wdata_i;
      if (we_i.msk)      mask_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign act_o  = pend_q & ~mask_q;

  // R1
  set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i.set |=> ((pend_o & $past(wdata_i)) == $past(wdata_i)));
  // R2
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i.clr && !we_i.set) |=> ((pend_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/intr_pwr_gate.sv
module intr_pwr_gate #(
  parameter int unsigned HOLD_CYC = 30_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_i,
  output logic gate_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic          pwr_q, gate_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = pwr_i & ~pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= 1'b0;
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pwr_q <= pwr_i;
      if (rise) begin
        gate_q <= 1'b0;
        cnt_q  <= CW'(HOLD_CYC);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        // expiry only re-enables while power is still present
        if (cnt_q == CW'(1) && pwr_i) gate_q <= 1'b1;
      end
    end
  end

  assign gate_o = gate_q;

  // R8
  pwr_rise_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && !pwr_q) |=> !gate_o);
  // R9
  gate_rise_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(pwr_i));
endmodule

// File: rtl/intr_otg_status.sv
module intr_otg_status
  import intr_rollup_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vbus_i,
  input  logic          sess_i,
  output logic [DW-1:0] stat_o,
  output logic          vbus_chg_o
);
  logic vbus_q, sv_q, se_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbus_q <= 1'b0;
      sv_q   <= 1'b0;
      se_q   <= 1'b0;
    end else begin
      vbus_q <= vbus_i;
      sv_q   <= sess_i;
      se_q   <= ~sess_i;
    end
  end

  assign vbus_chg_o = vbus_i ^ vbus_q;

  always_comb begin
    stat_o            = '0;
    stat_o[ST_VBUS]   = vbus_q;
    stat_o[ST_SVALID] = sv_q;
    stat_o[ST_SEND]   = se_q;
  end

  // R11
  sess_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_i |=> (stat_o[ST_SVALID] && !stat_o[ST_SEND]));
  // R11
  sess_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sess_i |=> (!stat_o[ST_SVALID] && stat_o[ST_SEND]));
endmodule

// File: rtl/intr_rollup.sv
module intr_rollup
  import intr_rollup_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned HOLD_CYC = 30_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              vbus_i,
  input  logic              sess_i,
  input  logic              pwr_i,
  output logic              irq_o
);
  localparam int unsigned NSUB = 2;  // 0: USB core, 1: DMA
  localparam int unsigned HALF = DW / 2;
  localparam logic [DW-1:0] SUMM_BITS =
    (DW'(1) << BIT_RX) | (DW'(1) << BIT_TX) | (DW'(1) << BIT_DMA);

  logic           hit, wr_hit;
  logic [3:0]     sel;
  logic [DW-1:0]  pend_q, mask_q, cfg_q;
  logic [DW-1:0]  set_v, clr_v, chg_v, summ_v, pend_view;
  logic [DW-1:0]  sub_pend [NSUB];
  logic [DW-1:0]  sub_mask [NSUB];
  logic [DW-1:0]  sub_act  [NSUB];
  logic [DW-1:0]  stat;
  logic           vbus_chg, gate, any_act;

  assign hit    = (addr_i[ADDR_W-1:6] == '0) && (addr_i[1:0] == 2'b00);
  assign sel    = addr_i[5:2];
  assign wr_hit = wr_i & hit;

  for (genvar gi = 0; gi < NSUB; gi++) begin : g_sub
    localparam logic [3:0] BASE = 4'(int'(SEL_USB_PEND) + 4 * gi);
    bank_we_t we;
    assign we.set = wr_hit && (sel == BASE + 4'd1);
    assign we.clr = wr_hit && (sel == BASE + 4'd2);
    assign we.msk = wr_hit && (sel == BASE + 4'd3);
    intr_sub_bank #(.W(DW)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we),
      .wdata_i(wdata_i),
      .pend_o (sub_pend[gi]),
      .mask_o (sub_mask[gi]),
      .act_o  (sub_act[gi])
    );
  end

  intr_otg_status u_otg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vbus_i    (vbus_i),
    .sess_i    (sess_i),
    .stat_o    (stat),
    .vbus_chg_o(vbus_chg)
  );

  intr_pwr_gate #(.HOLD_CYC(HOLD_CYC)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pwr_i (pwr_i),
    .gate_o(gate)
  );

  always_comb begin
    summ_v          = '0;
    summ_v[BIT_TX]  = |sub_act[0][HALF-1:0];
    summ_v[BIT_RX]  = |sub_act[0][DW-1:HALF];
    summ_v[BIT_DMA] = |sub_act[1];
  end

  assign set_v = (wr_hit && sel == SEL_TOP_SET) ? wdata_i : '0;
  assign clr_v = (wr_hit && sel == SEL_TOP_CLR) ? wdata_i : '0;
  assign chg_v = vbus_chg ? (DW'(1) << BIT_VBUS_CHG) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
      cfg_q  <= '0;
    end else begin
      // summary positions are never stored; they are overlaid live
      pend_q <= (((pend_q | set_v) & ~clr_v) | chg_v) & ~SUMM_BITS;
      if (wr_hit && sel == SEL_TOP_MSK) mask_q <= wdata_i;
      if (wr_hit && sel == SEL_CFG)     cfg_q  <= wdata_i;
    end
  end

  assign pend_view = pend_q | summ_v;
  assign any_act   = |(pend_view & ~mask_q);
  assign irq_o     = gate & (cfg_q[CFG_POL_BIT] ? any_act : ~any_act);

  always_comb begin
    rdata_o = '0;
    if (rd_i && hit) begin
      unique case (sel)
        SEL_TOP_PEND, SEL_TOP_SET, SEL_TOP_CLR: rdata_o = pend_view;
        SEL_TOP_MSK:                            rdata_o = mask_q;
        SEL_USB_PEND, SEL_USB_SET, SEL_USB_CLR: rdata_o = sub_pend[0];
        SEL_USB_MSK:                            rdata_o = sub_mask[0];
        SEL_DMA_PEND, SEL_DMA_SET, SEL_DMA_CLR: rdata_o = sub_pend[1];
        SEL_DMA_MSK:                            rdata_o = sub_mask[1];
        SEL_CFG:                                rdata_o = cfg_q;
        SEL_STAT:                               rdata_o = stat;
        default:                                rdata_o = '0;
      endcase
    end
  end

  // R10
  vbus_chg_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[ST_VBUS] != $past(stat[ST_VBUS])) |-> pend_q[BIT_VBUS_CHG]);
  // R7
  gate_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate |-> !irq_o);
  // R5
  dma_summ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_pend[1] & ~sub_mask[1]) == '0 |-> !pend_view[BIT_DMA]);
endmodule

// File: tb/intr_rollup_bench.sv
module intr_rollup_bench;
  localparam int unsigned H = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        vbus = 1'b0, sess = 1'b0, pwr = 1'b0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  intr_rollup #(.ADDR_W(8), .HOLD_CYC(H)) u_intr_rollup (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .vbus_i(vbus), .sess_i(sess),
    .pwr_i(pwr), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    addr = a; rd = 1'b1;
    #1;
    chk(tag, rdata, exp);
    rd = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R3 top mask", 8'h0C, 32'hFFFF_FFFF);
    rd_chk("R3 top pend", 8'h00, 32'h0);
    rd_chk("R3 usb mask", 8'h1C, 32'h0);
    rd_chk("R3 dma mask", 8'h2C, 32'h0);
    rd_chk("R3 cfg", 8'h30, 32'h0);
    chk("R3 irq", 32'(irq), 32'h0);
    addr = 8'h0C; #1;
    chk("R1 rdata idle", rdata, 32'h0);
    rd_chk("R11 session end at rest", 8'h34, 32'h80);
  endtask

  task automatic t_power_up;
    @(negedge clk); pwr = 1'b1;
    repeat (H) @(negedge clk);
    chk("R8 gate still off at H-1", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R8 gate on at H", 32'(irq), 32'h1);
  endtask

  task automatic t_power_fall;
    @(negedge clk); pwr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 fall keeps gate", 32'(irq), 32'h1);
    pwr = 1'b1;
    @(negedge clk);
    chk("R8 rise drops gate", 32'(irq), 32'h0);
    repeat (5) @(negedge clk);
    pwr = 1'b0;
    repeat (H + 5) @(negedge clk);
    chk("R9 no restore without power", 32'(irq), 32'h0);
    pwr = 1'b1;
    repeat (H + 2) @(negedge clk);
    chk("R8 restore after full hold", 32'(irq), 32'h1);
  endtask

  task automatic t_polarity;
    wr_reg(8'h30, 32'h0002_0000);
    chk("R12 cfg write flips irq", 32'(irq), 32'h0);
    wr_reg(8'h04, 32'h0000_0008);
    chk("R7 masked pending quiet", 32'(irq), 32'h0);
    rd_chk("R1 read at set", 8'h04, 32'h8);
    rd_chk("R1 read at clear", 8'h08, 32'h8);
    wr_reg(8'h0C, 32'hFFFF_FFF7);
    chk("R12 mask write raises irq", 32'(irq), 32'h1);
    wr_reg(8'h04, 32'h0000_0040);
    rd_chk("R1 set ORs", 8'h00, 32'h48);
    wr_reg(8'h08, 32'h0000_0008);
    chk("R2 clear drops irq", 32'(irq), 32'h0);
    rd_chk("R2 clear only written bits", 8'h00, 32'h40);
    wr_reg(8'h08, 32'h0000_0040);
    wr_reg(8'h0C, ~32'h0100_8300);
  endtask

  task automatic t_usb;
    wr_reg(8'h14, 32'h0000_0001);
    rd_chk("R4 tx summary", 8'h00, 32'h200);
    chk("R4 irq from tx", 32'(irq), 32'h1);
    wr_reg(8'h14, 32'h0001_0000);
    rd_chk("R4 tx+rx summary", 8'h00, 32'h300);
    rd_chk("R1 usb pend", 8'h10, 32'h0001_0001);
    wr_reg(8'h1C, 32'h0000_FFFF);
    rd_chk("R4 low half masked", 8'h00, 32'h100);
    wr_reg(8'h1C, 32'hFFFF_0000);
    rd_chk("R4 high half masked", 8'h00, 32'h200);
    wr_reg(8'h1C, 32'h0);
    wr_reg(8'h18, 32'h0001_0001);
    rd_chk("R4 cleared", 8'h00, 32'h0);
    chk("R4 irq idle", 32'(irq), 32'h0);
  endtask

  task automatic t_dma;
    wr_reg(8'h24, 32'h0000_0004);
    rd_chk("R5 dma summary", 8'h00, 32'h0100_0000);
    wr_reg(8'h2C, 32'h0000_0004);
    rd_chk("R5 masked dma clears", 8'h00, 32'h0);
    wr_reg(8'h2C, 32'h0);
    rd_chk("R5 unmasked again", 8'h00, 32'h0100_0000);
    wr_reg(8'h28, 32'h0000_0004);
    rd_chk("R5 dma cleared", 8'h00, 32'h0);
  endtask

  task automatic t_summary_locked;
    wr_reg(8'h04, 32'h0100_0301);
    rd_chk("R6 summary bits not settable", 8'h00, 32'h1);
    wr_reg(8'h24, 32'h1);
    wr_reg(8'h08, 32'h0100_0000);
    rd_chk("R6 summary bit not clearable", 8'h00, 32'h0100_0001);
    wr_reg(8'h28, 32'h1);
    wr_reg(8'h08, 32'h1);
    rd_chk("R6 idle", 8'h00, 32'h0);
  endtask

  task automatic t_vbus;
    @(negedge clk); vbus = 1'b1;
    @(negedge clk);
    rd_chk("R10 status vbus", 8'h34, 32'hA0);
    rd_chk("R10 change pending", 8'h00, 32'h8000);
    wr_reg(8'h08, 32'h8000);
    repeat (4) @(negedge clk);
    rd_chk("R10 steady no event", 8'h00, 32'h0);
    vbus = 1'b0;
    @(negedge clk);
    rd_chk("R10 fall event", 8'h00, 32'h8000);
    rd_chk("R10 status low", 8'h34, 32'h80);
    wr_reg(8'h08, 32'h8000);
  endtask

  task automatic t_session;
    @(negedge clk); sess = 1'b1;
    @(negedge clk);
    rd_chk("R11 session valid", 8'h34, 32'h40);
    rd_chk("R11 no interrupt", 8'h00, 32'h0);
    sess = 1'b0;
    @(negedge clk);
    rd_chk("R11 session end", 8'h34, 32'h80);
    rd_chk("R11 no interrupt end", 8'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_power_up;
    t_power_fall;
    t_polarity;
    t_usb;
    t_dma;
    t_summary_locked;
    t_vbus;
    t_session;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule